// File: doc/BRIEF.md
# Two-Wire Bus Read Master

This block is a bus master for the two-wire serial bus. It reads a run of bytes from a slave with a 7-bit address. When the internal address length is nonzero, the master first writes one to three internal address bytes. It then issues a repeated start and switches to reading. Software controls the block through a small command side:

- a start request and a stop request;
- the slave address;
- the internal address length and value;
- a receive holding register with a ready flag.

On the bus side the block drives both lines through open-drain pull-low enables and samples both lines back.

Software ends a read by raising the stop request at a fixed point in the transfer:

- **Single-byte read:** raise stop together with start.
- **Longer read:** raise stop once the next-to-last byte has arrived.

The byte received after the stop request is the last one. The master NACKs it and then sends a stop condition. The master holds the clock low while the holding register is still unread, so no byte is lost. A NACK during the address or internal address phase ends the transfer and raises an error flag.

Top module: `tw_read_master`

## Requirements
- R1: After reset both bus enables are released (0), `done` is 1, and `rx_ready` and `nack_err` are 0.
- R2: The first byte after a start is the 7-bit slave address, most significant bit first, followed by the direction bit. The direction bit is 1 for a read and 0 for a write. When `ia_len` is 0 that first byte carries the read bit.
- R3: When `ia_len` is 1, 2 or 3, the master does the following, in order:
  - sends the address with the write bit;
  - sends the low `ia_len` bytes of `ia_value`, most significant byte first;
  - issues a repeated start;
  - resends the address with the read bit.
  The transfer contains exactly two start conditions.
- R4: When a byte has been received, `rx_data` holds it and `rx_ready` is 1. A one-cycle `rx_take` pulse clears `rx_ready`.
- R5: The master ACKs every received byte except the last one. It NACKs the last byte and then sends exactly one stop condition.
- R6: When `go` and `halt` are pulsed in the same cycle, exactly one byte is read.
- R7: When `halt` is pulsed after the next-to-last byte has been received, exactly one more byte is read, and it is the last.
- R8: `done` falls when a transfer is accepted, stays 0 while the transfer runs, and returns to 1 after the stop condition.
- R9: When the slave NACKs the address or an internal address byte, the master sends a stop condition, sets `nack_err`, and delivers no data.
- R10: While `rx_ready` is 1 and the next byte is complete, the master holds the clock low and makes no clock edges until `rx_take`. The held byte is then delivered intact.
- R11: The data line changes while the clock is high only for a start condition (falling data) or a stop condition (rising data).
- R12: Each bit lasts 4*(`div`+1) clock cycles when no device stretches the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start request pulse; accepted only when idle |
| halt | input | 1 | Stop request pulse; marks the next received byte as the last |
| slave_id | input | 7 | Slave address |
| ia_len | input | LEN_W | Number of internal address bytes, 0 to IA_BYTES |
| ia_value | input | 8*IA_BYTES | Internal address value, low bytes used |
| div | input | DIV_W | Clock divider; one bit phase lasts div+1 cycles |
| rx_take | input | 1 | Read strobe for the holding register |
| rx_data | output | 8 | Receive holding register |
| rx_ready | output | 1 | Holding register has unread data |
| done | output | 1 | Transmission complete flag |
| nack_err | output | 1 | Address or internal address was not acknowledged |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| scl_in | input | 1 | Sampled clock line |
| sda_in | input | 1 | Sampled data line |

## Verification
The assertions rely on the following conditions on the inputs:

- `rx_take` is only pulsed by a reader that saw `rx_ready`.
- `halt` is never raised in the same cycle that a byte is being taken into the holding register.
- No other device drives the data line high-to-low while the clock is high, except through normal slave acknowledge and data timing.

The bench's slave model changes the data line only on falling clock edges. Commands and reads are driven on the falling system-clock edge. The stop request is issued in the read-strobe cycle of the next-to-last byte, which is far from the next load.

// File: rtl/tw_read_master.sv
module tw_read_master #(
  parameter int DIV_W    = 8,
  parameter int IA_BYTES = 3,
  localparam int LEN_W   = $clog2(IA_BYTES + 1),
  localparam int IA_W    = 8 * IA_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             halt,
  input  logic [6:0]       slave_id,
  input  logic [LEN_W-1:0] ia_len,
  input  logic [IA_W-1:0]  ia_value,
  input  logic [DIV_W-1:0] div,
  input  logic             rx_take,
  output logic [7:0]       rx_data,
  output logic             rx_ready,
  output logic             done,
  output logic             nack_err,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             scl_in,
  input  logic             sda_in
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_TX, S_RX, S_STOP} st_t;

  st_t              st;
  logic [1:0]       ph;
  logic [2:0]       bitc;
  logic [7:0]       sh, ia_byte;
  logic             ackb, rep, rdph, loaded, last, stop_pend, got_nack;
  logic [LEN_W-1:0] irem;
  logic [IA_W-1:0]  ia_q;
  logic [6:0]       dev_q;
  logic [DIV_W-1:0] cnt;
  logic             scl_low, sda_low, wait_rd, hold, tick;

  always_comb begin
    scl_low = 1'b0;
    sda_low = 1'b0;
    case (st)
      S_START: begin scl_low = (ph == 2'd0 && rep) || ph == 2'd3; sda_low = ph[1]; end
      S_TX:    begin scl_low = ph == 2'd0 || ph == 2'd3; sda_low = !ackb && !sh[7]; end
      S_RX:    begin scl_low = ph == 2'd0 || ph == 2'd3; sda_low = ackb && loaded && !last; end
      S_STOP:  begin scl_low = ph == 2'd0; sda_low = !ph[1]; end
      default: ;
    endcase
  end

  always_comb begin
    ia_byte = 8'h00;
    for (int k = 0; k < IA_BYTES; k++)
      if (irem == LEN_W'(k + 1)) ia_byte = ia_q[8*k +: 8];
  end

  assign scl_oe  = scl_low;
  assign sda_oe  = sda_low;
  assign wait_rd = st == S_RX && ackb && !loaded;
  assign hold    = (!scl_low && !scl_in) || wait_rd;
  assign tick    = !hold && cnt == div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (st == S_IDLE || tick) cnt <= '0;
    else if (!hold) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 2'd0; bitc <= 3'd0; sh <= 8'h00;
      ackb <= 1'b0; rep <= 1'b0; rdph <= 1'b0; loaded <= 1'b0; last <= 1'b0;
      stop_pend <= 1'b0; got_nack <= 1'b0; irem <= '0; ia_q <= '0; dev_q <= 7'h00;
      rx_data <= 8'h00; rx_ready <= 1'b0; done <= 1'b1; nack_err <= 1'b0;
    end else begin
      if (halt && st != S_IDLE) stop_pend <= 1'b1;
      if (rx_take) rx_ready <= 1'b0;
      if (wait_rd && (!rx_ready || rx_take)) begin
        rx_data <= sh; rx_ready <= 1'b1; loaded <= 1'b1; last <= stop_pend;
      end
      if (st == S_IDLE) begin
        if (go) begin
          st <= S_START; ph <= 2'd0; rep <= 1'b0; done <= 1'b0; nack_err <= 1'b0;
          stop_pend <= halt; dev_q <= slave_id; ia_q <= ia_value; irem <= ia_len;
        end
      end else if (tick) begin
        ph <= ph + 2'd1;
        case (st)
          S_START:
            if (ph == 2'd3) begin
              st <= S_TX; sh <= {dev_q, irem == '0}; rdph <= irem == '0;
              bitc <= 3'd0; ackb <= 1'b0;
            end
          S_TX: begin
            if (ph == 2'd1 && ackb) got_nack <= sda_in;
            if (ph == 2'd3) begin
              if (!ackb) begin
                bitc <= bitc + 3'd1;
                sh   <= {sh[6:0], 1'b0};
                if (bitc == 3'd7) ackb <= 1'b1;
              end else begin
                ackb <= 1'b0;
                if (got_nack) begin nack_err <= 1'b1; st <= S_STOP; end
                else if (rdph) st <= S_RX;
                else if (irem != '0) begin sh <= ia_byte; irem <= irem - 1'b1; end
                else begin st <= S_START; rep <= 1'b1; end
              end
            end
          end
          S_RX: begin
            if (ph == 2'd1 && !ackb) sh <= {sh[6:0], sda_in};
            if (ph == 2'd3) begin
              if (!ackb) begin
                bitc <= bitc + 3'd1;
                if (bitc == 3'd7) ackb <= 1'b1;
              end else begin
                ackb <= 1'b0; loaded <= 1'b0;
                if (last) st <= S_STOP;
              end
            end
          end
          S_STOP:
            if (ph == 2'd3) begin st <= S_IDLE; done <= 1'b1; stop_pend <= 1'b0; end
          default: ;
        endcase
      end
    end
  end

  // R8
  busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st != S_IDLE |-> !done);

  // R4
  rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> $past(rx_take));

  // R10
  no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && !rx_take && st == S_RX |=> $stable(rx_data));

  // R10
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_rd |-> scl_oe);

  // R11
  start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) && !scl_oe && !$past(scl_oe) |-> st == S_START);

  // R11
  stop_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) && !scl_oe && !$past(scl_oe) |-> st == S_STOP);

  // R9
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_err) |-> st == S_STOP);

endmodule

// File: tb/tw_read_master_bench.sv
module tw_read_master_bench;
  localparam logic [6:0] SLV = 7'h52;

  logic clk = 1'b0, rst_n = 1'b0;
  logic go = 0, halt = 0, rx_take = 0;
  logic [6:0] slave_id = SLV;
  logic [1:0] ia_len = 0;
  logic [23:0] ia_value = 0;
  logic [7:0] div = 8'd3;
  logic [7:0] rx_data;
  logic rx_ready, done, nack_err, scl_oe, sda_oe;
  logic slv_drv = 1'b0;
  logic scl_bus, sda_bus;

  assign scl_bus = !scl_oe;
  assign sda_bus = !(sda_oe || slv_drv);

  always #5 clk = ~clk;

  tw_read_master u_tw_read_master (
    .clk(clk), .rst_n(rst_n), .go(go), .halt(halt), .slave_id(slave_id),
    .ia_len(ia_len), .ia_value(ia_value), .div(div), .rx_take(rx_take),
    .rx_data(rx_data), .rx_ready(rx_ready), .done(done), .nack_err(nack_err),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_bus), .sda_in(sda_bus));

  int n_chk = 0, n_err = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mem(input logic [7:0] p);
    return p * 8'd5 + 8'h3C;
  endfunction

  // slave model
  logic p_scl = 1, p_sda = 1;
  int s_mode = 0, s_cnt = 0;
  logic [7:0] s_sh, s_tx, s_ptr = 8'h00;
  logic s_first = 0, s_inack = 0, s_rd = 0, s_match = 0, s_mack = 0;
  int s_starts, s_stops, s_acks, s_nacks, s_rises, s_ia_n, s_period, s_last_rise;
  int nack_at_ia = 0;
  logic [7:0] s_addr0, s_addr1;
  logic [23:0] s_ia;

  always @(negedge clk) begin
    if (scl_bus && p_scl && p_sda && !sda_bus) begin
      s_mode = 1; s_cnt = 0; s_first = 1; s_inack = 0; slv_drv = 0;
      s_starts++;
    end else if (scl_bus && p_scl && !p_sda && sda_bus) begin
      s_mode = 0; slv_drv = 0; s_stops++;
    end else if (scl_bus && !p_scl) begin
      s_rises++;
      if (s_mode == 2 && s_cnt >= 1 && s_cnt < 8) s_period = cyc - s_last_rise;
      s_last_rise = cyc;
      if (s_mode == 1 && s_cnt < 8) begin s_sh = {s_sh[6:0], sda_bus}; s_cnt++; end
      else if (s_mode == 2 && s_cnt == 8) begin
        s_mack = !sda_bus;
        if (sda_bus) s_nacks++; else s_acks++;
      end
    end else if (!scl_bus && p_scl) begin
      if (s_mode == 1) begin
        if (s_cnt == 8 && !s_inack) begin
          s_inack = 1;
          if (s_first) begin
            if (s_starts == 1) s_addr0 = s_sh; else s_addr1 = s_sh;
            s_rd = s_sh[0]; s_match = s_sh[7:1] == SLV;
            slv_drv = s_match;
          end else begin
            s_ia = {s_ia[15:0], s_sh}; s_ptr = s_sh; s_ia_n++;
            slv_drv = s_ia_n != nack_at_ia;
            if (s_ia_n == nack_at_ia) s_match = 0;
          end
        end else if (s_inack) begin
          s_inack = 0; slv_drv = 0; s_cnt = 0;
          if (!s_match) s_mode = 0;
          else if (s_first && s_rd) begin
            s_mode = 2; s_tx = mem(s_ptr); slv_drv = !s_tx[7];
          end
          s_first = 0;
        end
      end else if (s_mode == 2) begin
        if (s_cnt == 8) begin
          if (s_mack) begin
            s_ptr = s_ptr + 8'd1; s_tx = mem(s_ptr); s_cnt = 0; slv_drv = !s_tx[7];
          end else begin s_mode = 0; slv_drv = 0; end
        end else begin
          s_cnt++;
          slv_drv = (s_cnt < 8) ? !s_tx[7 - s_cnt] : 1'b0;
        end
      end
    end
    p_scl = scl_bus; p_sda = sda_bus;
  end

  task automatic chk(input logic ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic clr_stats();
    s_starts = 0; s_stops = 0; s_acks = 0; s_nacks = 0; s_ia_n = 0;
    s_ia = 0; s_period = 0; s_addr0 = 0; s_addr1 = 0;
  endtask

  task automatic wait_rdy(output logic ok);
    ok = 0;
    for (int t = 0; t < 8000; t++) begin
      @(negedge clk);
      if (rx_ready) begin ok = 1; break; end
    end
    if (!ok) chk(0, "R4 rx_ready timeout", 0, 1);
  endtask

  task automatic wait_done();
    logic ok = 0;
    for (int t = 0; t < 8000; t++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
    chk(ok, "R8 done after stop", done, 1);
  endtask

  task automatic issue(input logic [6:0] a, input logic [1:0] len, input logic [23:0] ia, input logic stp);
    @(negedge clk);
    slave_id = a; ia_len = len; ia_value = ia; go = 1; halt = stp;
    @(negedge clk);
    go = 0; halt = 0;
    repeat (3) @(negedge clk);
    chk(done == 0, "R8 done low while busy", done, 0);
  endtask

  task automatic t_reset();
    chk(scl_oe == 0 && sda_oe == 0, "R1 bus released", {scl_oe, sda_oe}, 0);
    chk(done == 1, "R1 done", done, 1);
    chk(rx_ready == 0 && nack_err == 0, "R1 flags", {rx_ready, nack_err}, 0);
  endtask

  task automatic t_read(input logic [1:0] len, input logic [23:0] ia, input int n,
                        input int stall_k, input int stall_d);
    logic [7:0] base;
    logic ok;
    logic [23:0] mask;
    int r0;
    clr_stats();
    base = (len != 0) ? ia[7:0] : s_ptr;
    mask = (len == 1) ? 24'hFF : (len == 2) ? 24'hFFFF : 24'hFFFFFF;
    issue(SLV, len, ia, n == 1);
    for (int i = 0; i < n; i++) begin
      wait_rdy(ok);
      if (!ok) break;
      if (i == stall_k) begin
        repeat (stall_d / 2) @(negedge clk);
        r0 = s_rises;
        repeat (stall_d / 2) @(negedge clk);
        chk(scl_oe == 1 && s_rises == r0, "R10 clock held low", s_rises - r0, 0);
      end
      chk(rx_data == mem(base + 8'(i)), "R4/R7 data byte", rx_data, mem(base + 8'(i)));
      rx_take = 1;
      if (i == n - 2) halt = 1;
      @(negedge clk);
      rx_take = 0; halt = 0;
      if (i != stall_k) chk(rx_ready == 0, "R4 ready cleared", rx_ready, 0);
    end
    wait_done();
    chk(nack_err == 0, "R9 no error", nack_err, 0);
    chk(s_acks == n - 1, "R5/R6/R7 acked bytes", s_acks, n - 1);
    chk(s_nacks == 1, "R5 last byte nacked", s_nacks, 1);
    chk(s_stops == 1, "R5/R11 one stop", s_stops, 1);
    chk(s_starts == ((len != 0) ? 2 : 1), "R3/R11 start count", s_starts, (len != 0) ? 2 : 1);
    chk(s_addr0 == {SLV, len == 0}, "R2 address byte", s_addr0, {SLV, len == 0});
    if (len != 0) begin
      chk(s_addr1 == {SLV, 1'b1}, "R3 read address", s_addr1, {SLV, 1'b1});
      chk(s_ia_n == int'(len), "R3 ia byte count", s_ia_n, len);
      chk(s_ia[23:0] == (ia & mask), "R3 ia bytes msb first", s_ia, ia & mask);
    end
    chk(s_period == 4 * (int'(div) + 1), "R12 bit period", s_period, 4 * (int'(div) + 1));
    chk(rx_ready == 0, "R6/R7 no extra byte", rx_ready, 0);
  endtask

  task automatic t_nack(input logic [6:0] a, input logic [1:0] len, input int at);
    clr_stats();
    nack_at_ia = at;
    issue(a, len, 24'h3C4D5E, 1'b0);
    wait_done();
    nack_at_ia = 0;
    chk(nack_err == 1, "R9 nack_err set", nack_err, 1);
    chk(rx_ready == 0, "R9 no data", rx_ready, 0);
    chk(s_stops == 1, "R9 stop sent", s_stops, 1);
    chk(s_starts == 1, "R9 no repeated start", s_starts, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    clr_stats();
    repeat (2) @(negedge clk);
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_read(2'd0, 24'h0, 1, -1, 0);
    t_read(2'd1, 24'h000040, 3, -1, 0);
    t_read(2'd2, 24'h001280, 2, -1, 0);
    t_read(2'd3, 24'hABCD10, 4, 1, 600);
    t_read(2'd0, 24'h0, 2, -1, 0);
    div = 8'd1;
    t_read(2'd1, 24'h0000F0, 3, -1, 0);
    div = 8'd3;
    t_nack(7'h13, 2'd0, 0);
    t_nack(SLV, 2'd3, 2);
    t_read(2'd1, 24'h000007, 1, -1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule